// File: doc/BRIEF.md
# Serial Peripheral Port with Sticky Status Flags

This block is an 8-bit synchronous serial port that a processor drives through a small register bus with three addresses: control, status and data. It can run as the clock-driving master or as a selected slave. One fixed clock mode is supported: SCK idles low, input bits are sampled on the rising SCK edge, output bits change on the falling edge, and bytes travel most significant bit first. In master mode, writing the data register loads the shift register and starts a byte. In slave mode, that write only preloads the byte that goes out on MISO. In both modes, a finished byte is copied into a receive buffer, and software reads that buffer at the data address.

Four status flags report events. They are transfer complete, write collision, receive overrun and master-mode fault. Three of them can raise a single interrupt line. Most flags clear only through a two-step access: a status read, then a later data or control access. A transfer-complete flag that is still pending blocks new data writes until software has read the status register. A mode fault takes the port out of master mode so it stops driving the bus.

Register addresses: control = 0, status = 1, data = 2 (address 3 reads 00h). Control bits: bit 0 interrupt enable, bit 1 port enable, bit 2 master select; other bits read 0. Status bits: bit 7 transfer complete, bit 6 write collision, bit 5 overrun, bit 4 mode fault (these four are read-only), bit 3 reads 0, bit 2 output disable, bit 1 software select enable, bit 0 software select level (0 = selected).

Top module: `spi_stat_periph`

## Requirements
- R1: After reset, the control and status registers both read 00h, the interrupt is low, and `sck_oe`, `mosi_oe` and `miso_oe` are all low.
- R2: With port enable = 1 and master = 1, a data write accepted while idle sends that byte MSB first on MOSI. SCK idles low and each SCK half period lasts HALF_DIV clocks. MISO is sampled on each rising SCK edge. After eight SCK pulses, status bit 7 sets and the data address returns the received byte.
- R3: Status bit 7 clears only when a status read that saw it set is followed by a data read or data write. A data access with no such earlier status read leaves it set.
- R4: While status bit 7 is set and no status read has seen it, a data write is discarded: no SCK pulse is produced and no new byte is received.
- R5: A data write while a byte is in progress is discarded and sets status bit 6. The byte on the bus is not altered. Bit 6 clears when a status read that saw it set is followed by a data access.
- R6: If a byte completes while status bit 7 is still set, status bit 5 sets and the receive buffer keeps the earlier byte. Bit 5 clears on the next status read.
- R7: When port enable = 1, master = 1 and the internal select is low, status bit 4 sets and control bits 1 and 2 clear, so `sck_oe` and `mosi_oe` drop. Bit 4 clears only when a status read that saw it set is followed by a control write.
- R8: The interrupt output is high exactly when control bit 0 is 1 and at least one of status bits 7, 5 or 4 is 1.
- R9: The data address returns the receive buffer, never the live shift register. A byte written to start a new transfer is not visible at the data address.
- R10: Status bit 2 = 1 turns off `mosi_oe` in master mode and `miso_oe` in slave mode. SCK driving is not affected.
- R11: With status bit 1 = 1, the internal select follows status bit 0 (0 = selected) and the `ss_i` pin is ignored, both for slave selection and for fault detection.
- R12: In slave mode with the internal select low, the port samples MOSI on rising SCK and shifts MISO out of the preloaded byte on falling SCK. After eight SCK pulses it sets status bit 7 and buffers the received byte. `miso_oe` is high only while the port is enabled, selected and not output-disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for `sck_o` |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for `mosi_o` |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for `miso_o` |
| ss_i | input | 1 | Slave-select pin, active low |

## Verification
The bench builds the block with HALF_DIV = 3 and SYNC_STAGES = 2. An odd, non-power-of-two half period checks that the divider compare is not tied to a power of two, while each master byte stays short (48 clocks). The bench drives the slave-side SCK with a half period of eight clocks. That is slow enough to pass through the two-stage synchronizer, and it keeps back-to-back slave bytes short enough to force an overrun without any software access between them.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  // control register bit positions
  localparam int CB_IRQ = 0;
  localparam int CB_EN  = 1;
  localparam int CB_MST = 2;

  // status register bit positions (software decodes these)
  localparam int SB_DONE = 7;
  localparam int SB_WCOL = 6;
  localparam int SB_OVR  = 5;
  localparam int SB_MODF = 4;
  localparam int SB_ODIS = 2;
  localparam int SB_SWSS = 1;
  localparam int SB_SSLV = 0;

  typedef struct packed {
    logic done;
    logic wcol;
    logic ovr;
    logic modf;
  } sp_flags_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sp_engine.sv
module sp_engine #(
  parameter int W        = 8,
  parameter int HALF_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         miso_i,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic         ss_sel,
  output logic         sck_o,
  output logic         tx_bit,
  output logic         busy,
  output logic         xfer_done,
  output logic [W-1:0] rx_byte
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg_q, shreg_d;
  logic             samp_q, samp_d;
  logic [CNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [DIV_W-1:0] divcnt_q, divcnt_d;
  logic             sck_q, sck_d;
  logic             mact_q, mact_d;
  logic             sact_q, sact_d;
  logic             sprev_q, sprev_d;
  logic             done_q, done_d;

  logic tick, s_rise, s_fall;

  assign tick   = (divcnt_q == DIV_LAST);
  assign s_rise = sck_s & ~sprev_q;
  assign s_fall = ~sck_s & sprev_q;

  always_comb begin
    shreg_d  = shreg_q;
    samp_d   = samp_q;
    bitcnt_d = bitcnt_q;
    divcnt_d = divcnt_q;
    sck_d    = sck_q;
    mact_d   = mact_q;
    sact_d   = sact_q;
    sprev_d  = sck_s;
    done_d   = 1'b0;
    if (!en) begin
      mact_d   = 1'b0;
      sact_d   = 1'b0;
      sck_d    = 1'b0;
      bitcnt_d = '0;
      divcnt_d = '0;
    end else if (master) begin
      sact_d = 1'b0;
      if (load) begin
        shreg_d  = load_data;
        mact_d   = 1'b1;
        divcnt_d = '0;
        sck_d    = 1'b0;
        bitcnt_d = '0;
      end else if (mact_q) begin
        divcnt_d = tick ? '0 : divcnt_q + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_d  = 1'b1;
            samp_d = miso_i;
          end else begin
            sck_d   = 1'b0;
            shreg_d = {shreg_q[W-2:0], samp_q};
            if (bitcnt_q == BIT_LAST) begin
              bitcnt_d = '0;
              mact_d   = 1'b0;
              done_d   = 1'b1;
            end else begin
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end
        end
      end
    end else begin
      mact_d = 1'b0;
      sck_d  = 1'b0;
      if (load) begin
        shreg_d = load_data;
      end else if (!ss_sel) begin
        bitcnt_d = '0;
        sact_d   = 1'b0;
      end else begin
        if (s_rise) begin
          samp_d = mosi_s;
          sact_d = 1'b1;
        end
        if (s_fall && sact_q) begin
          shreg_d = {shreg_q[W-2:0], samp_q};
          if (bitcnt_q == BIT_LAST) begin
            bitcnt_d = '0;
            sact_d   = 1'b0;
            done_d   = 1'b1;
          end else begin
            bitcnt_d = bitcnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      samp_q   <= 1'b0;
      bitcnt_q <= '0;
      divcnt_q <= '0;
      sck_q    <= 1'b0;
      mact_q   <= 1'b0;
      sact_q   <= 1'b0;
      sprev_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      shreg_q  <= shreg_d;
      samp_q   <= samp_d;
      bitcnt_q <= bitcnt_d;
      divcnt_q <= divcnt_d;
      sck_q    <= sck_d;
      mact_q   <= mact_d;
      sact_q   <= sact_d;
      sprev_q  <= sprev_d;
      done_q   <= done_d;
    end
  end

  assign sck_o     = sck_q;
  assign tx_bit    = shreg_q[W-1];
  assign busy      = mact_q | sact_q;
  assign xfer_done = done_q;
  assign rx_byte   = shreg_q;
endmodule

// File: rtl/sp_flags.sv
module sp_flags
  import spi_sp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      data_rd,
  input  logic      data_wr,
  input  logic      ctrl_wr,
  input  logic      xfer_done,
  input  logic      busy,
  input  logic      fault,
  output sp_flags_t flg,
  output logic      wr_ok,
  output logic      buf_ld
);
  sp_flags_t flg_q, flg_d;
  logic arm_done_q, arm_done_d;
  logic arm_wcol_q, arm_wcol_d;
  logic arm_modf_q, arm_modf_d;
  logic data_acc;

  assign data_acc = data_rd | data_wr;
  assign wr_ok    = data_wr & ~busy & (~flg_q.done | arm_done_q);
  assign buf_ld   = xfer_done & ~flg_q.done;

  always_comb begin
    flg_d      = flg_q;
    arm_done_d = arm_done_q;
    arm_wcol_d = arm_wcol_q;
    arm_modf_d = arm_modf_q;

    if (stat_rd) begin
      arm_done_d = flg_q.done;
      arm_wcol_d = flg_q.wcol;
      arm_modf_d = flg_q.modf;
    end
    if (data_acc) begin
      arm_done_d = 1'b0;
      arm_wcol_d = 1'b0;
    end
    if (ctrl_wr) arm_modf_d = 1'b0;

    if (xfer_done)                  flg_d.done = 1'b1;
    else if (data_acc && arm_done_q) flg_d.done = 1'b0;

    if (data_wr && busy)             flg_d.wcol = 1'b1;
    else if (data_acc && arm_wcol_q) flg_d.wcol = 1'b0;

    if (xfer_done && flg_q.done) flg_d.ovr = 1'b1;
    else if (stat_rd)            flg_d.ovr = 1'b0;

    if (fault)                       flg_d.modf = 1'b1;
    else if (ctrl_wr && arm_modf_q)  flg_d.modf = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q      <= '0;
      arm_done_q <= 1'b0;
      arm_wcol_q <= 1'b0;
      arm_modf_q <= 1'b0;
    end else begin
      flg_q      <= flg_d;
      arm_done_q <= arm_done_d;
      arm_wcol_q <= arm_wcol_d;
      arm_modf_q <= arm_modf_d;
    end
  end

  assign flg = flg_q;
endmodule

// File: rtl/spi_stat_periph.sv
module spi_stat_periph
  import spi_sp_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_i
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  // register decode
  logic ctrl_wr, stat_wr, stat_rd, data_rd, data_wr;
  assign ctrl_wr = reg_wr & (reg_addr == ADR_CTRL);
  assign stat_wr = reg_wr & (reg_addr == ADR_STAT);
  assign stat_rd = reg_rd & (reg_addr == ADR_STAT);
  assign data_wr = reg_wr & (reg_addr == ADR_DATA);
  assign data_rd = reg_rd & (reg_addr == ADR_DATA);

  // pin synchronizers {ss, mosi, sck}
  logic [2:0] pins_s;
  logic       sck_s, mosi_s, ss_s;
  sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_q),
    .d    ({ss_i, mosi_i, sck_i}),
    .q    (pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;

  // configuration registers
  logic irq_en_q, irq_en_d;
  logic en_q, en_d;
  logic mst_q, mst_d;
  logic odis_q, odis_d;
  logic swss_q, swss_d;
  logic sslv_q, sslv_d;
  logic [BYTE_W-1:0] rx_buf, rx_buf_d;

  logic ss_int, ss_sel, fault;
  assign ss_int = swss_q ? sslv_q : ss_s;
  assign ss_sel = ~ss_int;
  assign fault  = en_q & mst_q & ~ss_int;

  // engine and flags
  logic              tx_bit, busy, xfer_done, wr_ok, buf_ld;
  logic [BYTE_W-1:0] rx_byte;
  sp_flags_t         flg;
  logic              done, ovr, modf;

  sp_engine #(.W(BYTE_W), .HALF_DIV(HALF_DIV)) u_engine (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en_q),
    .master   (mst_q),
    .load     (wr_ok),
    .load_data(reg_wdata),
    .miso_i   (miso_i),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .ss_sel   (ss_sel),
    .sck_o    (sck_o),
    .tx_bit   (tx_bit),
    .busy     (busy),
    .xfer_done(xfer_done),
    .rx_byte  (rx_byte)
  );

  sp_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_q),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .ctrl_wr  (ctrl_wr),
    .xfer_done(xfer_done),
    .busy     (busy),
    .fault    (fault),
    .flg      (flg),
    .wr_ok    (wr_ok),
    .buf_ld   (buf_ld)
  );

  assign done = flg.done;
  assign ovr  = flg.ovr;
  assign modf = flg.modf;

  always_comb begin
    irq_en_d = irq_en_q;
    en_d     = en_q;
    mst_d    = mst_q;
    odis_d   = odis_q;
    swss_d   = swss_q;
    sslv_d   = sslv_q;
    rx_buf_d = rx_buf;
    if (ctrl_wr) begin
      irq_en_d = reg_wdata[CB_IRQ];
      en_d     = reg_wdata[CB_EN];
      mst_d    = reg_wdata[CB_MST];
    end
    if (fault) begin
      en_d  = 1'b0;
      mst_d = 1'b0;
    end
    if (stat_wr) begin
      odis_d = reg_wdata[SB_ODIS];
      swss_d = reg_wdata[SB_SWSS];
      sslv_d = reg_wdata[SB_SSLV];
    end
    if (buf_ld) rx_buf_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_en_q <= 1'b0;
      en_q     <= 1'b0;
      mst_q    <= 1'b0;
      odis_q   <= 1'b0;
      swss_q   <= 1'b0;
      sslv_q   <= 1'b0;
      rx_buf   <= '0;
    end else begin
      irq_en_q <= irq_en_d;
      en_q     <= en_d;
      mst_q    <= mst_d;
      odis_q   <= odis_d;
      swss_q   <= swss_d;
      sslv_q   <= sslv_d;
      rx_buf   <= rx_buf_d;
    end
  end

  // read mux
  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = {5'b0, mst_q, en_q, irq_en_q};
      ADR_STAT: reg_rdata = {flg.done, flg.wcol, flg.ovr, flg.modf,
                             1'b0, odis_q, swss_q, sslv_q};
      ADR_DATA: reg_rdata = rx_buf;
      default:  reg_rdata = '0;
    endcase
  end

  logic odis;
  assign odis    = odis_q;
  assign irq     = irq_en_q & (flg.done | flg.ovr | flg.modf);
  assign sck_oe  = en_q & mst_q;
  assign mosi_o  = tx_bit;
  assign mosi_oe = en_q & mst_q & ~odis_q;
  assign miso_o  = tx_bit;
  assign miso_oe = en_q & ~mst_q & ss_sel & ~odis_q;
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_q,
  input logic       xfer_done,
  input logic       done,
  input logic       ovr,
  input logic       modf,
  input logic       data_rd,
  input logic       data_wr,
  input logic       wr_ok,
  input logic       busy,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe,
  input logic       odis,
  input logic [7:0] rx_buf
);
  assert_done_follows_xfer_R2: assert property (@(posedge clk) disable iff (!rst_q)
    xfer_done |=> done);

  assert_done_clear_by_data_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(done) |-> $past(data_rd || data_wr));

  assert_rejected_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (data_wr && !wr_ok && !busy) |=> !busy);

  assert_ovr_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(ovr) |-> $past(done));

  assert_buffer_held_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (done && $past(done)) |-> $stable(rx_buf));

  assert_fault_stops_clock_R7: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(modf) |-> !sck_oe);

  assert_outdis_R10: assert property (@(posedge clk) disable iff (!rst_q)
    odis |-> (!mosi_oe && !miso_oe));
endmodule

bind spi_stat_periph sp_checker i_sp_checker (
  .clk      (clk),
  .rst_q    (rst_q),
  .xfer_done(xfer_done),
  .done     (done),
  .ovr      (ovr),
  .modf     (modf),
  .data_rd  (data_rd),
  .data_wr  (data_wr),
  .wr_ok    (wr_ok),
  .busy     (busy),
  .sck_oe   (sck_oe),
  .mosi_oe  (mosi_oe),
  .miso_oe  (miso_oe),
  .odis     (odis),
  .rx_buf   (rx_buf)
);

// File: tb/test_spi_stat_periph.sv
`timescale 1ns/1ps
module test_spi_stat_periph;
  localparam int HALF    = 3;
  localparam int MWAIT   = 16 * HALF + 12;
  localparam int SLV_HP  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
  logic       miso_i;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_stat_periph #(.HALF_DIV(HALF), .SYNC_STAGES(2)) i_spi_stat_periph (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i)
  );

  // external slave model for master tests
  int        fall_total = 0;
  int        rise_total = 0;
  int        mdl_base = 0;
  logic [7:0] mdl_byte = 8'h00;
  logic [7:0] mosi_cap = 8'h00;
  always @(negedge sck_o) fall_total <= fall_total + 1;
  always @(posedge sck_o) begin
    rise_total <= rise_total + 1;
    mosi_cap   <= {mosi_cap[6:0], mosi_o};
  end
  always_comb begin
    int idx;
    idx = fall_total - mdl_base;
    miso_i = (idx >= 0 && idx < 8) ? mdl_byte[7 - idx] : 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mst_start(input logic [7:0] tx, input logic [7:0] rx);
    mdl_byte = rx;
    mdl_base = fall_total;
    bus_wr(2'd2, tx);
  endtask

  task automatic slv_byte(input logic [7:0] b, output logic [7:0] cap);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi_i = b[i];
      wait_clk(SLV_HP);
      sck_i = 1'b1;
      cap[i] = miso_o;
      wait_clk(SLV_HP);
      sck_i = 1'b0;
    end
    wait_clk(10);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    bus_rd(2'd1, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);
  endtask

  task automatic t_master_basic;
    logic [7:0] v;
    bus_wr(2'd0, 8'h07);
    mst_start(8'hA5, 8'h3C);
    wait_clk(MWAIT);
    chk("R2 mosi byte", mosi_cap, 8'hA5);
    chk("R8 irq on done", irq, 1);
    bus_rd(2'd2, v); chk("R2 rx byte", v, 8'h3C);
    bus_rd(2'd1, v); chk("R3 done kept without status read", v, 8'h80);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); chk("R3 done cleared", v, 8'h00);
    chk("R8 irq low", irq, 0);
    // R9: new byte in shift register must not show at data address
    mst_start(8'h55, 8'hC6);
    wait_clk(10);
    bus_rd(2'd2, v); chk("R9 buffer not shift reg", v, 8'h3C);
    wait_clk(MWAIT);
    bus_rd(2'd1, v); chk("R2 second done", v, 8'h80);
    bus_rd(2'd2, v); chk("R2 second rx", v, 8'hC6);
    chk("R2 second mosi", mosi_cap, 8'h55);
  endtask

  task automatic t_lockout;
    logic [7:0] v;
    int r0;
    mst_start(8'h12, 8'h34);
    wait_clk(MWAIT);
    r0 = rise_total;
    bus_wr(2'd2, 8'h77);
    wait_clk(MWAIT);
    chk("R4 no sck pulses", rise_total - r0, 0);
    bus_rd(2'd1, v); chk("R4 status after locked write", v, 8'h80);
    bus_rd(2'd2, v); chk("R4 buffer unchanged", v, 8'h34);
    bus_rd(2'd1, v); chk("R3 cleared", v, 8'h00);
  endtask

  task automatic t_wcol;
    logic [7:0] v;
    mst_start(8'hE1, 8'h9B);
    wait_clk(12);
    bus_wr(2'd2, 8'h0F);
    bus_rd(2'd1, v); chk("R5 wcol set", v, 8'h40);
    wait_clk(MWAIT);
    chk("R5 byte unaltered", mosi_cap, 8'hE1);
    bus_rd(2'd1, v); chk("R5 wcol and done", v, 8'hC0);
    bus_rd(2'd2, v); chk("R5 rx", v, 8'h9B);
    bus_rd(2'd1, v); chk("R5 both cleared", v, 8'h00);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_slave;
    logic [7:0] v, cap;
    bus_wr(2'd0, 8'h03);
    ss_i = 1'b0;
    wait_clk(5);
    chk("R12 miso_oe selected", miso_oe, 1);
    bus_wr(2'd2, 8'hC3);
    slv_byte(8'h96, cap);
    chk("R12 miso byte", cap, 8'hC3);
    chk("R8 irq slave", irq, 1);
    bus_rd(2'd1, v); chk("R12 done", v, 8'h80);
    bus_rd(2'd2, v); chk("R12 rx", v, 8'h96);
    // R6 overrun: two bytes with no software access between
    slv_byte(8'h21, cap);
    slv_byte(8'h84, cap);
    bus_rd(2'd1, v); chk("R6 ovr and done", v, 8'hA0);
    bus_rd(2'd1, v); chk("R6 ovr cleared by status read", v, 8'h80);
    bus_rd(2'd2, v); chk("R6 old byte kept", v, 8'h21);
    bus_rd(2'd1, v); chk("R6 all clear", v, 8'h00);
    ss_i = 1'b1;
    wait_clk(5);
    chk("R12 miso_oe deselected", miso_oe, 0);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_modf;
    logic [7:0] v;
    bus_wr(2'd0, 8'h07);
    chk("R7 sck_oe before", sck_oe, 1);
    ss_i = 1'b0;
    wait_clk(6);
    chk("R7 sck_oe dropped", sck_oe, 0);
    chk("R7 mosi_oe dropped", mosi_oe, 0);
    chk("R8 irq on fault", irq, 1);
    bus_rd(2'd0, v); chk("R7 ctrl bits cleared", v, 8'h01);
    bus_wr(2'd0, 8'h01);
    bus_rd(2'd1, v); chk("R7 fault kept without status read", v, 8'h10);
    ss_i = 1'b1;
    wait_clk(5);
    bus_wr(2'd0, 8'h01);
    bus_rd(2'd1, v); chk("R7 fault cleared", v, 8'h00);
    chk("R8 irq cleared", irq, 0);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_outdis;
    logic [7:0] v;
    bus_wr(2'd0, 8'h06);
    bus_wr(2'd1, 8'h04);
    bus_rd(2'd1, v); chk("R10 status readback", v, 8'h04);
    chk("R10 mosi_oe off", mosi_oe, 0);
    chk("R10 sck_oe kept", sck_oe, 1);
    bus_wr(2'd1, 8'h00);
    chk("R10 mosi_oe on", mosi_oe, 1);
    bus_wr(2'd0, 8'h02);
    ss_i = 1'b0;
    wait_clk(5);
    chk("R10 miso_oe on", miso_oe, 1);
    bus_wr(2'd1, 8'h04);
    chk("R10 miso_oe off", miso_oe, 0);
    bus_wr(2'd1, 8'h00);
    ss_i = 1'b1;
    bus_wr(2'd0, 8'h00);
    wait_clk(5);
  endtask

  task automatic t_swss;
    logic [7:0] v, cap;
    ss_i = 1'b0;
    bus_wr(2'd1, 8'h03);
    bus_wr(2'd0, 8'h06);
    wait_clk(6);
    bus_rd(2'd1, v); chk("R11 pin ignored no fault", v, 8'h03);
    bus_rd(2'd0, v); chk("R11 master kept", v, 8'h06);
    bus_wr(2'd0, 8'h00);
    ss_i = 1'b1;
    bus_wr(2'd1, 8'h02);
    bus_wr(2'd0, 8'h02);
    wait_clk(5);
    bus_wr(2'd2, 8'h3A);
    slv_byte(8'h6C, cap);
    chk("R11 miso via sw select", cap, 8'h3A);
    bus_rd(2'd1, v); chk("R11 done via sw select", v, 8'h82);
    bus_rd(2'd2, v); chk("R11 rx", v, 8'h6C);
    bus_rd(2'd1, v); chk("R11 cleared", v, 8'h02);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h00);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_master_basic();
    t_lockout();
    t_wcol();
    t_slave();
    t_modf();
    t_outdis();
    t_swss();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule